// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one read or write burst to a synchronous DRAM. A start pulse loads a start column, a burst length code and an ordering choice. The block then presents one column address per beat. The beat moves forward on each clock where the advance input is high. A separate signal marks the final beat of a fixed-length burst.

Two orderings are available, each wrapping inside a block aligned to the burst length. Sequential ordering counts upward within the block. Interleaved ordering flips the low address bits with a beat counter. A full-page burst walks the whole row and wraps from the top column back to zero. It continues until a stop request ends it. A start that arrives during a running burst replaces that burst, so bursts can follow one another with no idle cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and until the first start, `valid_o` is 0, `last_o` is 0 and `col_o` is 0. `col_o` is also 0 on any cycle where `valid_o` is 0.
- R2: On the clock after a cycle with `start_i` high, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`. The length code and the ordering are also sampled at the start.
- R3: Length codes map as follows: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and 7 gives a full page. Codes 4, 5 and 6 behave as a 1-beat burst.
- R4: With `order_i` = 0 (sequential), beat n is formed in two parts. The bits above the low log2(BL) bits of the start column are kept. The low log2(BL) bits equal (start + n) mod BL.
- R5: With `order_i` = 1 (interleaved), the low log2(BL) bits of beat n equal the start's low bits XOR n, and the upper bits are kept. In full-page mode, `order_i` has no effect and the count is always sequential.
- R6: The beat moves forward only on clock edges where `advance_i` is 1. On other edges `col_o` and `valid_o` hold.
- R7: `last_o` is 1 on the final beat of a fixed-length burst. If that beat is advanced with no start or stop in the same cycle, `valid_o` is 0 on the next cycle.
- R8: A full-page burst covers 2^COL_W columns (512 by default), wraps from 511 to 0, and never raises `last_o`.
- R9: If `stop_i` is 1 and `start_i` is 0, `valid_o` is 0 on the next cycle. This applies at every burst length, including full page.
- R10: A start during a running burst aborts it, and the next cycle shows the new start column as beat 0. When start and stop are high in the same cycle, start wins.
- R11: A start on the same edge as the advance of a final beat gives the next burst's first address on the next cycle, with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| advance_i | input | 1 | Move to the next beat |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Several control events can meet on the same clock edge, and the bench forces each of these collisions on purpose:
- A start during an advance, including on the final beat.
- A start together with a stop.
- A stop on the final beat.

Each collision is judged against a reference model held in the bench, which applies the priority order start, then stop, then advance. The bench predicts the address, valid flag and last flag for the following cycle, and a scoreboard compares that prediction with the design's outputs.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [2:0] {
    BLEN_1    = 3'd0,
    BLEN_2    = 3'd1,
    BLEN_4    = 3'd2,
    BLEN_8    = 3'd3,
    BLEN_PAGE = 3'd7
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    case (code_i)
      BLEN_2:    mask_o = COL_W'(1);
      BLEN_4:    mask_o = COL_W'(3);
      BLEN_8:    mask_o = COL_W'(7);
      BLEN_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:   mask_o = '0;
    endcase
  end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] addr_o
);

  logic             use_xor;
  logic [COL_W-1:0] low_w;

  always_comb begin
    use_xor = (order_i == ORD_ILV) && !full_i;
    low_w   = use_xor ? (base_i ^ beat_i) : (base_i + beat_i);
    addr_o  = (base_i & ~mask_i) | (low_w & mask_i);
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             advance_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] beat_q, beat_d;
  logic             valid_q, valid_d;
  logic             final_w;

  assign final_w = valid_q && !full_i && (beat_q == mask_i);

  always_comb begin
    beat_d  = beat_q;
    valid_d = valid_q;
    if (start_i) begin
      beat_d  = '0;
      valid_d = 1'b1;
    end else if (stop_i) begin
      valid_d = 1'b0;
    end else if (advance_i && valid_q) begin
      if (final_w) valid_d = 1'b0;
      else         beat_d  = beat_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      beat_q  <= beat_d;
      valid_q <= valid_d;
    end
  end

  assign beat_o  = beat_q;
  assign valid_o = valid_q;
  assign last_o  = final_w;

  AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && advance_i && !start_i && !stop_i |=> !valid_o) else $error("final beat did not end"); // R7
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !valid_o) else $error("stop ignored"); // R9

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             order_i,
  input  logic             advance_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic             rst_sn;
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;

  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic             full_q, full_d;
  order_e           ord_q, ord_d;

  logic [COL_W-1:0] beat_w;
  logic             valid_w;
  logic             last_w;
  logic [COL_W-1:0] addr_w;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (blen_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  always_comb begin
    base_d = base_q;
    mask_d = mask_q;
    full_d = full_q;
    ord_d  = ord_q;
    if (start_i) begin
      base_d = start_col_i;
      mask_d = dec_mask;
      full_d = dec_full;
      ord_d  = order_e'(order_i);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ord_q  <= ORD_SEQ;
    end else begin
      base_q <= base_d;
      mask_q <= mask_d;
      full_q <= full_d;
      ord_q  <= ord_d;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_sn),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .advance_i (advance_i),
    .mask_i    (mask_q),
    .full_i    (full_q),
    .beat_o    (beat_w),
    .valid_o   (valid_w),
    .last_o    (last_w)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i  (base_q),
    .beat_i  (beat_w),
    .mask_i  (mask_q),
    .full_i  (full_q),
    .order_i (ord_q),
    .addr_o  (addr_w)
  );

  assign col_o   = valid_w ? addr_w : '0;
  assign valid_o = valid_w;
  assign last_o  = last_w;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_sn)
    start_i |=> valid_o && (col_o == $past(start_col_i))) else $error("start col wrong"); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_o && !advance_i && !start_i && !stop_i |=> valid_o && $stable(col_o)) else $error("beat moved"); // R6
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_o && advance_i && !last_o && !start_i && !stop_i && (ord_q == ORD_SEQ || full_q)
    |=> (((col_o - $past(col_o)) & mask_q) == COL_W'(1)) && (((col_o ^ $past(col_o)) & ~mask_q) == '0))
    else $error("sequential step wrong"); // R4
  AST_ILV_UPPER: assert property (@(posedge clk) disable iff (!rst_sn)
    valid_o && advance_i && !last_o && !start_i && !stop_i && ord_q == ORD_ILV
    |=> ((col_o ^ $past(col_o)) & ~mask_q) == '0) else $error("interleave left block"); // R5
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    full_q |-> !last_o) else $error("last in full page"); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    !valid_o |-> !last_o && col_o == '0) else $error("idle outputs not zero"); // R1

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

  localparam int COL_W = 9;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i, order_i, advance_i, stop_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       blen_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic             v;
    logic [COL_W-1:0] c;
    logic             l;
    string            tag;
  } exp_t;

  exp_t sb[$];

  int  m_base, m_beat, m_len;
  bit  m_full, m_ilv, m_valid;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .order_i(order_i), .advance_i(advance_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic bit m_last();
    return m_valid && !m_full && (m_beat == m_len - 1);
  endfunction

  function automatic int m_col();
    int blk, low;
    if (!m_valid) return 0;
    if (m_full) return (m_base + m_beat) % PAGE;
    blk = m_base - (m_base % m_len);
    low = m_ilv ? ((m_base ^ m_beat) % m_len) : ((m_base + m_beat) % m_len);
    return blk + low;
  endfunction

  task automatic step(input bit st, input int col, input int code, input bit typ,
                      input bit adv, input bit stp, input string tag);
    exp_t e;
    @(negedge clk);
    start_i = st; start_col_i = COL_W'(col); blen_i = 3'(code);
    order_i = typ; advance_i = adv; stop_i = stp;
    if (st) begin
      m_base = col; m_beat = 0; m_valid = 1; m_ilv = typ; m_full = 0;
      case (code)
        1: m_len = 2;
        2: m_len = 4;
        3: m_len = 8;
        7: begin m_len = PAGE; m_full = 1; end
        default: m_len = 1;
      endcase
    end else if (stp) begin
      m_valid = 0;
    end else if (adv && m_valid) begin
      if (m_last()) m_valid = 0;
      else m_beat = (m_beat + 1) % PAGE;
    end
    e.v = m_valid; e.c = COL_W'(m_col()); e.l = m_last(); e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (valid_o !== e.v || col_o !== e.c || last_o !== e.l) begin
        errors++;
        $display("FAIL %s: got v=%0b col=%0d last=%0b exp v=%0b col=%0d last=%0b",
                 e.tag, valid_o, col_o, last_o, e.v, e.c, e.l);
      end
    end
  end

  task automatic run_adv(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0, tag);
  endtask

  initial begin
    #(20000 * 10);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_valid = 0; m_base = 0; m_beat = 0; m_len = 1; m_full = 0; m_ilv = 0;
    rst_n = 1'b0; start_i = 0; start_col_i = '0; blen_i = '0;
    order_i = 0; advance_i = 0; stop_i = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || col_o !== '0) begin
      errors++;
      $display("FAIL R1: got v=%0b col=%0d last=%0b exp 0 0 0", valid_o, col_o, last_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step(0, 0, 0, 0, 1, 0, "R1 idle after reset");

    // R2 R4 R7: length 4 sequential from 6 -> 6,7,4,5
    step(1, 6, 2, 0, 0, 0, "R2 start loads column");
    run_adv(4, "R4 R7 sequential 4 wrap");
    step(0, 0, 0, 0, 0, 0, "R7 ended burst idle");

    // R5: length 8 interleaved from 19
    step(1, 19, 3, 1, 0, 0, "R5 interleave start");
    run_adv(8, "R5 interleave 8");

    // R3: lengths 2, 1 and reserved code 5
    step(1, 101, 1, 0, 0, 0, "R3 length 2");
    run_adv(2, "R3 length 2 beats");
    step(1, 40, 0, 1, 0, 0, "R3 length 1");
    run_adv(1, "R3 length 1 ends");
    step(1, 41, 5, 0, 0, 0, "R3 reserved code");
    run_adv(1, "R3 reserved code ends");

    // R6: advance gaps in length 8 sequential
    step(1, 250, 3, 0, 0, 0, "R6 start");
    step(0, 0, 0, 0, 0, 0, "R6 hold");
    step(0, 0, 0, 0, 1, 0, "R6 move");
    step(0, 0, 0, 0, 0, 0, "R6 hold again");
    step(0, 0, 0, 0, 1, 0, "R6 move again");
    // R9 stop mid burst
    step(0, 0, 0, 0, 1, 1, "R9 stop fixed length");
    step(0, 0, 0, 0, 1, 0, "R9 stays idle");

    // R8 R5: full page, interleave ignored, wraps
    step(1, 509, 7, 1, 0, 0, "R8 full page start");
    run_adv(5, "R8 R5 full page wrap");
    step(0, 0, 0, 0, 0, 0, "R8 hold in page");
    step(0, 0, 0, 0, 0, 1, "R9 stop full page");

    // R10: restart mid burst, start beats stop
    step(1, 32, 3, 0, 0, 0, "R10 first burst");
    run_adv(2, "R10 first burst beats");
    step(1, 77, 2, 1, 1, 0, "R10 restart mid burst");
    step(0, 0, 0, 0, 1, 0, "R10 new burst beat");
    step(1, 200, 1, 0, 0, 1, "R10 start over stop");
    step(0, 0, 0, 0, 1, 0, "R10 after start over stop");

    // R11: back-to-back on final beat; R7/R9 stop on last
    step(1, 12, 1, 0, 0, 0, "R11 burst A");
    step(0, 0, 0, 0, 1, 0, "R11 burst A last");
    step(1, 3, 2, 1, 1, 0, "R11 burst B no gap");
    run_adv(3, "R11 burst B beats");
    step(0, 0, 0, 0, 1, 1, "R9 stop on last beat");

    step(0, 0, 0, 0, 0, 0, "R1 idle tail");
    @(negedge clk);
    start_i = 0; advance_i = 0; stop_i = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule